// File: doc/BRIEF.md
# Mode-Dependent Port Pin Function Multiplexer

This block controls one 8-bit I/O port. For each pin it decides whether the pin is a general-purpose input, a general-purpose output, or is taken over by a system or bus-control function. The decision depends on the operating mode, an expansion enable, a few function enables and the contents of a write-only direction register. A port data register gives the value of every pin that is a general-purpose output. A read of the port returns a mix of data-register bits and sampled pin levels.

The mode code is 3 bits. Codes 1, 2 and 4 are expanded modes. Code 7 is single-chip, unless `exp_en` is 1, in which case it is also expanded. Any code other than 7 is treated as expanded. The mode and enable inputs are static after reset, but any enable change still reaches the pins combinationally in the same cycle. The register port uses `wr_sel`/`rd_sel` = 0 for the direction register and 1 for the data register.

Pin roles when taken over:
- pin 7: system clock output
- pin 6: address strobe
- pin 5: read strobe
- pin 4: high-byte write strobe
- pin 3: low-byte write strobe
- pin 2: lower column strobe
- pin 1: upper column strobe
- pin 0: wait input

Top module: `portpin_mux`

## Requirements
- R1: During and after reset, direction bit 7 is 1 for every mode code except 7, where it is 0. Direction bits 6..0 and all data bits are 0.
- R2: A read with `rd_sel`=0 (direction register) always returns 8'h00.
- R3: In every mode, pin 7 has `pin_oe[7]`=1 and `pin_out[7]`=`sys_clk_i` when direction bit 7 is 1. When the bit is 0, pin 7 is an input.
- R4: In expanded operation with `as_en`=1, pin 6 is enabled and drives `as_i`. Otherwise pin 6 follows its direction bit.
- R5: In expanded operation, pins 5 and 4 are always enabled and drive `rd_i` and `hwr_i`, whatever their direction bits hold.
- R6: In expanded operation with `lwr_en`=1, pin 3 is enabled and drives `lwr_i`. Otherwise pin 3 follows its direction bit.
- R7: In expanded operation, `cas_lo_sel`=1 makes pin 2 drive `cas_lo_i`, and `cas_hi_sel`=1 makes pin 1 drive `cas_hi_i`. Each is otherwise governed by its direction bit.
- R8: In expanded operation with `wait_sel`=1, `pin_oe[0]`=0 and `wait_o`=`pin_in[0]`. In every other case `wait_o`=0.
- R9: In single-chip operation (mode 7, `exp_en`=0), pins 6..0 follow only their direction bits, and all function enables have no effect.
- R10: A pin governed by its direction bit drives the data register bit when its direction bit is 1. Any pin with `pin_oe`=0 has `pin_out`=0.
- R11: A read with `rd_sel`=1 returns the data register bit for each pin that is a general-purpose output, and `pin_in` for every other pin.
- R12: A write with `wr_en`=1 loads `wr_data` into the direction register (`wr_sel`=0) or the data register (`wr_sel`=1), visible from the next cycle.
- R13: A change to any function enable alters the pins in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Operating mode code (1, 2, 4 or 7) |
| exp_en | input | 1 | Expansion enable, used in mode 7 |
| as_en | input | 1 | Address-strobe takeover of pin 6 |
| lwr_en | input | 1 | Low-write-strobe takeover of pin 3 |
| cas_lo_sel | input | 1 | Lower column strobe on pin 2 |
| cas_hi_sel | input | 1 | Upper column strobe on pin 1 |
| wait_sel | input | 1 | Wait input on pin 0 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 direction, 1 data |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 direction, 1 port |
| rd_data | output | 8 | Read data |
| sys_clk_i | input | 1 | System clock to pin 7 |
| as_i | input | 1 | Address strobe from bus controller |
| rd_i | input | 1 | Read strobe from bus controller |
| hwr_i | input | 1 | High-byte write strobe |
| lwr_i | input | 1 | Low-byte write strobe |
| cas_lo_i | input | 1 | Lower column strobe |
| cas_hi_i | input | 1 | Upper column strobe |
| wait_o | output | 1 | Sampled wait level to bus controller |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench targets the following corner cases:
- **Reset value of direction bit 7.** This is checked under each of the four mode codes. A design that hard-codes the reset value would have the clock pin wrong in either mode 7 or the expanded modes.
- **Forced strobes on pins 5 and 4.** These are checked with direction bits cleared. A design that let the direction bits win would leave the read or write strobe floating.
- **Mode 7 with expansion off.** All enables are asserted here. A design that forgot the expansion gate would hand the pins to the bus controller in single-chip operation.
- **Pin 0 as the wait input.** The bench checks that the pin is never driven and that its level reaches `wait_o`.
- **Port read mask.** This is checked on patterns where input and output bits alternate. A design that used the direction bits instead of the actual pin role would return data-register bits for pins taken over by strobes.

// File: rtl/portpin_pkg.sv
package portpin_pkg;

    localparam int PORT_W   = 8;
    localparam int MODE_W   = 3;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'd7;

    localparam int PIN_CLK  = 7;
    localparam int PIN_AS   = 6;
    localparam int PIN_RD   = 5;
    localparam int PIN_HWR  = 4;
    localparam int PIN_LWR  = 3;
    localparam int PIN_CASL = 2;
    localparam int PIN_CASH = 1;
    localparam int PIN_WAIT = 0;

    typedef enum logic [1:0] {
        FN_GP_IN  = 2'd0,
        FN_GP_OUT = 2'd1,
        FN_ALT_OUT = 2'd2,
        FN_ALT_IN = 2'd3
    } pin_fn_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
    } port_regs_t;

endpackage

// File: rtl/portpin_regs.sv
module portpin_regs
    import portpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] op_mode,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] data_q
);

    port_regs_t        regs_d, regs_q;
    logic [PORT_W-1:0] dir_rst;

    // Only the clock pin's direction bit has a mode-dependent reset value
    always_comb begin
        dir_rst          = '0;
        dir_rst[PIN_CLK] = (op_mode != MODE_SINGLE);
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel) regs_d.data = wr_data;
            else        regs_d.dir  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir  <= dir_rst;
            regs_q.data <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_q  = regs_q.dir;
    assign data_q = regs_q.data;

endmodule

// File: rtl/portpin_fn_select.sv
module portpin_fn_select
    import portpin_pkg::*;
(
    input  logic [PORT_W-1:0]   dir_q,
    input  logic [PORT_W-1:0]   take,
    output pin_fn_e [PORT_W-1:0] fn
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i == PIN_CLK) begin : g_clk
            // The clock pin never becomes a general output
            always_comb fn[i] = take[i] ? FN_ALT_OUT : FN_GP_IN;
        end else if (i == PIN_WAIT) begin : g_wait
            always_comb begin
                if (take[i])      fn[i] = FN_ALT_IN;
                else if (dir_q[i]) fn[i] = FN_GP_OUT;
                else              fn[i] = FN_GP_IN;
            end
        end else begin : g_gen
            always_comb begin
                if (take[i])      fn[i] = FN_ALT_OUT;
                else if (dir_q[i]) fn[i] = FN_GP_OUT;
                else              fn[i] = FN_GP_IN;
            end
        end
    end

endmodule

// File: rtl/portpin_drive.sv
module portpin_drive
    import portpin_pkg::*;
(
    input  pin_fn_e [PORT_W-1:0] fn,
    input  logic [PORT_W-1:0]    alt_val,
    input  logic [PORT_W-1:0]    data_q,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe,
    output logic [PORT_W-1:0]    gp_out
);

    for (genvar i = 0; i < PORT_W; i++) begin : g_drv
        always_comb begin
            pin_out[i] = 1'b0;
            pin_oe[i]  = 1'b0;
            gp_out[i]  = 1'b0;
            unique case (fn[i])
                FN_ALT_OUT: begin
                    pin_out[i] = alt_val[i];
                    pin_oe[i]  = 1'b1;
                end
                FN_GP_OUT: begin
                    pin_out[i] = data_q[i];
                    pin_oe[i]  = 1'b1;
                    gp_out[i]  = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/portpin_mux.sv
module portpin_mux
    import portpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic              exp_en,
    input  logic              as_en,
    input  logic              lwr_en,
    input  logic              cas_lo_sel,
    input  logic              cas_hi_sel,
    input  logic              wait_sel,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              rd_sel,
    output logic [7:0]        rd_data,
    input  logic              sys_clk_i,
    input  logic              as_i,
    input  logic              rd_i,
    input  logic              hwr_i,
    input  logic              lwr_i,
    input  logic              cas_lo_i,
    input  logic              cas_hi_i,
    output logic              wait_o,
    input  logic [7:0]        pin_in,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_oe
);

    logic [PORT_W-1:0]    dir_q, data_q, take, alt_val, gp_out;
    pin_fn_e [PORT_W-1:0] fn;
    logic                 expanded;

    portpin_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_mode (op_mode),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    assign expanded = (op_mode != MODE_SINGLE) || exp_en;

    // Per-pin takeover requests, ahead of the direction bits
    always_comb begin
        take           = '0;
        take[PIN_CLK]  = dir_q[PIN_CLK];
        take[PIN_AS]   = expanded & as_en;
        take[PIN_RD]   = expanded;
        take[PIN_HWR]  = expanded;
        take[PIN_LWR]  = expanded & lwr_en;
        take[PIN_CASL] = expanded & cas_lo_sel;
        take[PIN_CASH] = expanded & cas_hi_sel;
        take[PIN_WAIT] = expanded & wait_sel;
    end

    always_comb begin
        alt_val           = '0;
        alt_val[PIN_CLK]  = sys_clk_i;
        alt_val[PIN_AS]   = as_i;
        alt_val[PIN_RD]   = rd_i;
        alt_val[PIN_HWR]  = hwr_i;
        alt_val[PIN_LWR]  = lwr_i;
        alt_val[PIN_CASL] = cas_lo_i;
        alt_val[PIN_CASH] = cas_hi_i;
    end

    portpin_fn_select u_sel (
        .dir_q (dir_q),
        .take  (take),
        .fn    (fn)
    );

    portpin_drive u_drv (
        .fn      (fn),
        .alt_val (alt_val),
        .data_q  (data_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .gp_out  (gp_out)
    );

    assign wait_o  = (fn[PIN_WAIT] == FN_ALT_IN) ? pin_in[PIN_WAIT] : 1'b0;
    assign rd_data = rd_sel ? ((data_q & gp_out) | (pin_in & ~gp_out)) : '0;

endmodule

// File: rtl/portpin_mux_chk.sv
module portpin_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] op_mode,
    input logic       exp_en,
    input logic       as_en,
    input logic       lwr_en,
    input logic       cas_lo_sel,
    input logic       cas_hi_sel,
    input logic       wait_sel,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       rd_sel,
    input logic [7:0] rd_data,
    input logic       sys_clk_i,
    input logic       as_i,
    input logic       rd_i,
    input logic       hwr_i,
    input logic       lwr_i,
    input logic       cas_lo_i,
    input logic       cas_hi_i,
    input logic       wait_o,
    input logic [7:0] pin_in,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe
);

    logic ext_bus;
    assign ext_bus = (op_mode != 3'd7) || exp_en;

    p_dir_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |-> rd_data == 8'h00);

    p_forced_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_bus |-> (pin_oe[5] && pin_oe[4] && pin_out[5] == rd_i && pin_out[4] == hwr_i));

    p_wait_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_bus && wait_sel) |-> (!pin_oe[0] && wait_o == pin_in[0]));

    p_single_chip_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_bus |-> !wait_o);

    p_quiet_inputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == 8'h00);

    p_dir_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> pin_oe[7] == $past(wr_data[7]));

endmodule

bind portpin_mux portpin_mux_chk u_chk (.*);

// File: tb/portpin_mux_test.sv
`timescale 1ns/1ps
module portpin_mux_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_mode;
    logic       exp_en, as_en, lwr_en, cas_lo_sel, cas_hi_sel, wait_sel;
    logic       wr_en, wr_sel, rd_sel;
    logic [7:0] wr_data, rd_data, pin_in, pin_out, pin_oe;
    logic       sys_clk_i, as_i, rd_i, hwr_i, lwr_i, cas_lo_i, cas_hi_i, wait_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench copies of register state, updated by the bench's own writes
    logic [7:0] m_dir, m_data;

    always #2 clk = ~clk;

    portpin_mux uut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_exp();
        return (op_mode != 3'd7) || exp_en;
    endfunction

    // Reference: returns {oe, out, general_output} for pin i
    function automatic logic [2:0] ref_pin(input int i);
        logic alt_on, alt_v;
        alt_on = 1'b0;
        alt_v  = 1'b0;
        if (i == 7) begin
            if (m_dir[7]) return {1'b1, sys_clk_i, 1'b0};
            return 3'b000;
        end
        if (is_exp()) begin
            case (i)
                6: begin alt_on = as_en;      alt_v = as_i;     end
                5: begin alt_on = 1'b1;       alt_v = rd_i;     end
                4: begin alt_on = 1'b1;       alt_v = hwr_i;    end
                3: begin alt_on = lwr_en;     alt_v = lwr_i;    end
                2: begin alt_on = cas_lo_sel; alt_v = cas_lo_i; end
                1: begin alt_on = cas_hi_sel; alt_v = cas_hi_i; end
                default: begin
                    if (wait_sel) return 3'b000;
                end
            endcase
        end
        if (alt_on) return {1'b1, alt_v, 1'b0};
        if (m_dir[i]) return {1'b1, m_data[i], 1'b1};
        return 3'b000;
    endfunction

    function automatic string pin_req(input int i);
        if (i == 7) return "R3";
        if (!is_exp()) return "R9";
        case (i)
            6: return "R4";
            5, 4: return "R5";
            3: return "R6";
            2, 1: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare_all();
        logic [7:0] exp_rd;
        logic [2:0] r;
        exp_rd = '0;
        for (int i = 0; i < 8; i++) begin
            r = ref_pin(i);
            chk(pin_req(i), $sformatf("pin%0d oe", i), int'(pin_oe[i]), int'(r[2]));
            chk(pin_req(i), $sformatf("pin%0d out", i), int'(pin_out[i]), int'(r[1]));
            exp_rd[i] = r[0] ? m_data[i] : pin_in[i];
        end
        chk("R10", "out with oe low", int'(pin_out & ~pin_oe), 0);
        chk("R8", "wait_o", int'(wait_o), int'(is_exp() && wait_sel ? pin_in[0] : 1'b0));
        rd_sel = 1'b1;
        #0.5;
        chk("R11", "port read", int'(rd_data), int'(exp_rd));
        rd_sel = 1'b0;
        #0.5;
        chk("R2", "direction read", int'(rd_data), 0);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] val);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (sel) m_data = val; else m_dir = val;
    endtask

    task automatic set_enables(input logic [4:0] e);
        {as_en, lwr_en, cas_lo_sel, cas_hi_sel, wait_sel} = e;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] modes [4];
        logic [7:0] dirs  [4];
        logic [7:0] datas [4];
        int cyc;
        modes = '{3'd1, 3'd2, 3'd4, 3'd7};
        dirs  = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
        datas = '{8'h3C, 8'hC3, 8'hFF, 8'h0F};
        cyc = 0;
        rst_n = 1'b0; op_mode = 3'd1; exp_en = 1'b0;
        set_enables(5'b0);
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
        pin_in = '0;
        {sys_clk_i, as_i, rd_i, hwr_i, lwr_i, cas_lo_i, cas_hi_i} = '0;
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 2; e++) begin
                @(posedge clk); #1;
                rst_n = 1'b0; op_mode = modes[m]; exp_en = e[0];
                set_enables(5'b0);
                #1;
                m_dir  = {(modes[m] != 3'd7), 7'b0};
                m_data = 8'h00;
                // R1: reset value of the direction register, seen on pin 7
                chk("R1", "pin7 oe in reset", int'(pin_oe[7]), int'(modes[m] != 3'd7));
                @(posedge clk); #1;
                rst_n = 1'b1;
                #1;
                chk("R1", "pin7 oe after reset", int'(pin_oe[7]), int'(modes[m] != 3'd7));
                compare_all();
                for (int p = 0; p < 4; p++) begin
                    write_reg(1'b0, dirs[p]);
                    // R12: the direction write is visible the next cycle
                    chk("R12", "pin7 oe after dir write", int'(pin_oe[7]), int'(dirs[p][7]));
                    write_reg(1'b1, datas[p]);
                    for (int en = 0; en < 32; en++) begin
                        for (int pi = 0; pi < 2; pi++) begin
                            @(posedge clk); #1;
                            cyc++;
                            set_enables(en[4:0]);
                            pin_in = pi[0] ? 8'h96 : 8'h69;
                            {sys_clk_i, as_i, rd_i, hwr_i, lwr_i, cas_lo_i, cas_hi_i} = 7'(cyc * 37);
                            #0.5;
                            compare_all();
                        end
                    end
                    // R13: a pin-6 enable toggle shows up with no clock edge
                    @(posedge clk); #1;
                    set_enables(5'b00000);
                    as_i = 1'b1;
                    #0.5;
                    as_en = 1'b1;
                    #0.5;
                    chk("R13", "pin6 oe same cycle", int'(pin_oe[6]), int'(is_exp() ? 1'b1 : m_dir[6]));
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule